// File: doc/BRIEF.md
# Uncached Read Burst Extractor

This block sits between a processor-side read port and a memory that only delivers whole bursts. A request names a byte address and a size of 1, 2, 4 or 8 bytes. The block issues one burst command covering the enclosing 64-byte line (eight 8-byte beats). It keeps the beat that holds the wanted bytes and returns only those bytes. They are shifted down to bit 0 and zero-filled above. A separate control pin selects a short mode. In that mode the burst is cut to four beats and starts at the 32-byte half of the line that holds the target. A free-running counter records every burst command the memory accepts.

Requests and responses use valid/ready channels. A request transfers on a clock edge where `req_valid` and `req_ready` are both high. The block accepts one request and then holds `req_ready` low until its response transfers, so at most one read is in flight. A raised `rsp_valid` stays up, and the response word stays constant, until `rsp_ready` is seen. The memory command is also valid/ready. Returned beats are pushed by the memory with `mem_rd_valid` and cannot be stalled, though gaps between beats are allowed.

Top module: `ucrd_extract`

## Requirements
- R1: In full mode the memory command address is the request address with its low 6 bits cleared, `mem_cmd_chop` is 0, and the block consumes exactly 8 beats.
- R2: A full 8-beat burst is fetched even when 1, 2 or 4 bytes are requested. The response appears on the cycle after the last beat is taken.
- R3: `req_size` encodes 0=1 byte, 1=2 bytes, 2=4 bytes, 3=8 bytes. Byte i of `rsp_data` (bits 8i+7..8i) equals memory byte address+i for i below the size, and all higher bytes are zero.
- R4: In short mode `mem_cmd_chop` is 1, the command address is the request address with its low 5 bits cleared, and the block consumes exactly 4 beats.
- R5: `burst_count` rises by exactly one for each memory command handshake and is otherwise unchanged. It wraps at its width.
- R6: A request whose address is not a multiple of its size returns `rsp_err`=1 with `rsp_data`=0. It issues no memory command and leaves `burst_count` unchanged.
- R7: `req_ready` is low from the cycle after a request is accepted until the cycle after its response transfers.
- R8: While `rsp_valid` is high and `rsp_ready` is low, `rsp_valid`, `rsp_data` and `rsp_err` hold their values.
- R9: `chop_en` is sampled when the request is accepted. Later changes do not affect that read.
- R10: After reset, `req_ready`=1, `rsp_valid`=0, `mem_cmd_valid`=0 and `burst_count`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chop_en | input | 1 | Selects the 4-beat short burst, sampled at request accept |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready, high only when idle |
| req_addr | input | AW (32) | Byte address of the read |
| req_size | input | 2 | Size code: 0=1, 1=2, 2=4, 3=8 bytes |
| mem_cmd_valid | output | 1 | Burst command valid |
| mem_cmd_ready | input | 1 | Memory accepts the command |
| mem_cmd_addr | output | AW (32) | Start address of the burst |
| mem_cmd_chop | output | 1 | Burst is the 4-beat short form |
| mem_rd_valid | input | 1 | A returned beat is present |
| mem_rd_data | input | 64 | Returned beat, lowest address in bits 7..0 |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Requester accepts the response |
| rsp_data | output | 64 | Requested bytes at bit 0, zero-extended |
| rsp_err | output | 1 | Misaligned request was rejected |
| burst_count | output | CW (16) | Number of bursts issued |

## Verification
Assertions check on every cycle that each command address is aligned to a line or half-line, that the counter steps once per command handshake, that the request port closes after an accept, and that a pending response does not move. They also check that a misaligned request goes straight to an error response and that the beat index stays within the burst length. Only the bench scenarios can show the correctness of the extracted bytes for each size and offset, and the half-line choice in short mode. The same holds for sampling of the mode pin at accept, for ignoring beats outside the target, and for the absence of any burst on a misaligned read.

// File: rtl/ucrd_pkg.sv
package ucrd_pkg;
  typedef enum logic [1:0] {
    SZ_1 = 2'd0,
    SZ_2 = 2'd1,
    SZ_4 = 2'd2,
    SZ_8 = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CMD   = 2'd1,
    ST_BEATS = 2'd2,
    ST_RESP  = 2'd3
  } state_e;
endpackage

// File: rtl/ucrd_lane_pick.sv
module ucrd_lane_pick #(
  parameter int DW = 64
) (
  input  logic [DW-1:0]             word_i,
  input  logic [$clog2(DW/8)-1:0]   off_i,
  input  logic [1:0]                size_i,
  output logic [DW-1:0]             data_o
);
  localparam int BYTES = DW / 8;
  localparam int OFF_W = $clog2(BYTES);

  logic [DW-1:0] shifted;
  logic [OFF_W:0] nbytes;

  always_comb begin
    shifted = word_i >> {off_i, 3'b000};
    nbytes  = (OFF_W+1)'(1) << size_i;
  end

  for (genvar k = 0; k < BYTES; k++) begin : g_lane
    always_comb begin
      if (k < int'(nbytes)) data_o[8*k +: 8] = shifted[8*k +: 8];
      else                  data_o[8*k +: 8] = 8'h00;
    end
  end
endmodule

// File: rtl/ucrd_beat_cap.sv
module ucrd_beat_cap #(
  parameter int DW    = 64,
  parameter int BEATS = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       start_i,
  input  logic                       chop_i,
  input  logic [$clog2(BEATS)-1:0]   tgt_idx_i,
  input  logic                       rd_valid_i,
  input  logic [DW-1:0]              rd_data_i,
  output logic [DW-1:0]              word_o,
  output logic                       done_o
);
  localparam int IDX_W = $clog2(BEATS);
  localparam logic [IDX_W-1:0] LAST_FULL = IDX_W'(BEATS - 1);
  localparam logic [IDX_W-1:0] LAST_CHOP = IDX_W'(BEATS / 2 - 1);

  logic             active;
  logic             chop_q;
  logic [IDX_W-1:0] tgt_q;
  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] last_idx;

  assign last_idx = chop_q ? LAST_CHOP : LAST_FULL;
  assign done_o   = active && rd_valid_i && (idx == last_idx);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      chop_q <= 1'b0;
      tgt_q  <= '0;
      idx    <= '0;
      word_o <= '0;
    end else if (start_i) begin
      active <= 1'b1;
      chop_q <= chop_i;
      tgt_q  <= tgt_idx_i;
      idx    <= '0;
    end else if (active && rd_valid_i) begin
      if (idx == tgt_q) word_o <= rd_data_i;
      if (idx == last_idx) active <= 1'b0;
      idx <= idx + 1'b1;
    end
  end

  assert_beat_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> (idx <= last_idx));
endmodule

// File: rtl/ucrd_ctrl.sv
module ucrd_ctrl
  import ucrd_pkg::*;
#(
  parameter int AW         = 32,
  parameter int BEATS      = 8,
  parameter int BEAT_BYTES = 8,
  parameter int CW         = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          chop_en,
  input  logic                          req_valid,
  output logic                          req_ready,
  input  logic [AW-1:0]                 req_addr,
  input  logic [1:0]                    req_size,
  output logic                          mem_cmd_valid,
  input  logic                          mem_cmd_ready,
  output logic [AW-1:0]                 mem_cmd_addr,
  output logic                          mem_cmd_chop,
  input  logic                          beats_done,
  output logic                          rsp_valid,
  input  logic                          rsp_ready,
  output logic                          rsp_err,
  output logic [CW-1:0]                 burst_count,
  output logic                          cmd_fire,
  output logic [$clog2(BEATS)-1:0]      tgt_idx,
  output logic [$clog2(BEAT_BYTES)-1:0] lane_off,
  output logic [1:0]                    lat_size
);
  localparam int OFF_W  = $clog2(BEAT_BYTES);
  localparam int IDX_W  = $clog2(BEATS);
  localparam int LINE_W = OFF_W + IDX_W;

  state_e         state;
  logic [AW-1:0]  lat_addr;
  logic           lat_chop;
  logic [OFF_W:0] size_mask;
  logic           misaligned;
  logic           req_fire;

  always_comb begin
    size_mask  = ((OFF_W+1)'(1) << req_size) - (OFF_W+1)'(1);
    misaligned = (req_addr[OFF_W-1:0] & size_mask[OFF_W-1:0]) != '0;
  end

  assign req_ready     = (state == ST_IDLE);
  assign req_fire      = req_valid && req_ready;
  assign mem_cmd_valid = (state == ST_CMD);
  assign cmd_fire      = mem_cmd_valid && mem_cmd_ready;
  assign rsp_valid     = (state == ST_RESP);
  assign mem_cmd_chop  = lat_chop;
  assign lane_off      = lat_addr[OFF_W-1:0];

  always_comb begin
    if (lat_chop) begin
      mem_cmd_addr = {lat_addr[AW-1:LINE_W-1], {(LINE_W-1){1'b0}}};
      tgt_idx      = IDX_W'(lat_addr[LINE_W-2:OFF_W]);
    end else begin
      mem_cmd_addr = {lat_addr[AW-1:LINE_W], {LINE_W{1'b0}}};
      tgt_idx      = lat_addr[LINE_W-1:OFF_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= ST_IDLE;
      lat_addr    <= '0;
      lat_size    <= 2'd0;
      lat_chop    <= 1'b0;
      rsp_err     <= 1'b0;
      burst_count <= '0;
    end else begin
      if (cmd_fire) burst_count <= burst_count + 1'b1;
      unique case (state)
        ST_IDLE: if (req_fire) begin
          lat_addr <= req_addr;
          lat_size <= req_size;
          lat_chop <= chop_en;
          rsp_err  <= misaligned;
          state    <= misaligned ? ST_RESP : ST_CMD;
        end
        ST_CMD:   if (cmd_fire)   state <= ST_BEATS;
        ST_BEATS: if (beats_done) state <= ST_RESP;
        ST_RESP:  if (rsp_ready)  state <= ST_IDLE;
        default:                  state <= ST_IDLE;
      endcase
    end
  end

  assert_cmd_aligned_R1: assert property (@(posedge clk) disable iff (!rst_n)
    mem_cmd_valid |-> (mem_cmd_addr[LINE_W-2:0] == '0) &&
                      (mem_cmd_chop || (mem_cmd_addr[LINE_W-1] == 1'b0)));

  assert_count_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_fire |=> (burst_count == $past(burst_count) + 1'b1));

  assert_count_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_fire |=> $stable(burst_count));

  assert_single_outstanding_R7: assert property (@(posedge clk) disable iff (!rst_n)
    req_fire |=> !req_ready);

  assert_err_direct_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_fire && misaligned) |=> (rsp_valid && rsp_err && !mem_cmd_valid));
endmodule

// File: rtl/ucrd_extract.sv
module ucrd_extract #(
  parameter int AW    = 32,
  parameter int DW    = 64,
  parameter int BEATS = 8,
  parameter int CW    = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chop_en,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [1:0]    req_size,
  output logic          mem_cmd_valid,
  input  logic          mem_cmd_ready,
  output logic [AW-1:0] mem_cmd_addr,
  output logic          mem_cmd_chop,
  input  logic          mem_rd_valid,
  input  logic [DW-1:0] mem_rd_data,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [DW-1:0] rsp_data,
  output logic          rsp_err,
  output logic [CW-1:0] burst_count
);
  localparam int BEAT_BYTES = DW / 8;
  localparam int OFF_W      = $clog2(BEAT_BYTES);
  localparam int IDX_W      = $clog2(BEATS);

  logic             cmd_fire;
  logic             beats_done;
  logic [IDX_W-1:0] tgt_idx;
  logic [OFF_W-1:0] lane_off;
  logic [1:0]       lat_size;
  logic [DW-1:0]    line_word;
  logic [DW-1:0]    picked;

  ucrd_ctrl #(
    .AW(AW), .BEATS(BEATS), .BEAT_BYTES(BEAT_BYTES), .CW(CW)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n), .chop_en(chop_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_chop(mem_cmd_chop),
    .beats_done(beats_done),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_err(rsp_err),
    .burst_count(burst_count), .cmd_fire(cmd_fire),
    .tgt_idx(tgt_idx), .lane_off(lane_off), .lat_size(lat_size)
  );

  ucrd_beat_cap #(.DW(DW), .BEATS(BEATS)) u_cap (
    .clk(clk), .rst_n(rst_n), .start_i(cmd_fire), .chop_i(mem_cmd_chop),
    .tgt_idx_i(tgt_idx), .rd_valid_i(mem_rd_valid), .rd_data_i(mem_rd_data),
    .word_o(line_word), .done_o(beats_done)
  );

  ucrd_lane_pick #(.DW(DW)) u_pick (
    .word_i(line_word), .off_i(lane_off), .size_i(lat_size), .data_o(picked)
  );

  assign rsp_data = rsp_err ? '0 : picked;

  assert_rsp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data) && $stable(rsp_err)));
endmodule

// File: tb/ucrd_extract_bench.sv
module ucrd_extract_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        chop_en = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic [1:0]  req_size = '0;
  logic        mem_cmd_valid;
  logic        mem_cmd_ready = 1'b0;
  logic [31:0] mem_cmd_addr;
  logic        mem_cmd_chop;
  logic        mem_rd_valid = 1'b0;
  logic [63:0] mem_rd_data = '0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic [63:0] rsp_data;
  logic        rsp_err;
  logic [15:0] burst_count;

  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  ucrd_extract u_ucrd_extract (
    .clk(clk), .rst_n(rst_n), .chop_en(chop_en),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_size(req_size),
    .mem_cmd_valid(mem_cmd_valid), .mem_cmd_ready(mem_cmd_ready),
    .mem_cmd_addr(mem_cmd_addr), .mem_cmd_chop(mem_cmd_chop),
    .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
    .rsp_data(rsp_data), .rsp_err(rsp_err), .burst_count(burst_count)
  );

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return a[7:0] * 8'd13 + a[15:8] + 8'h21;
  endfunction

  function automatic logic [63:0] mbeat(input logic [31:0] a);
    logic [63:0] d;
    for (int i = 0; i < 8; i++) d[8*i +: 8] = mbyte(a + 32'(i));
    return d;
  endfunction

  function automatic logic [63:0] want(input logic [31:0] a, input logic [1:0] sz);
    logic [63:0] d = '0;
    for (int i = 0; i < (1 << sz); i++) d[8*i +: 8] = mbyte(a + 32'(i));
    return d;
  endfunction

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One read: gap_cmd negedges of command stall, hold_rsp negedges of response stall
  task automatic do_read(input logic [31:0] addr, input logic [1:0] sz, input logic chop,
                         input int gap_cmd, input int hold_rsp);
    logic [15:0] cnt0;
    logic        mis;
    logic [31:0] base;
    int          nbeats;
    logic [63:0] exp;
    mis    = (addr[2:0] & ((3'd1 << sz) - 3'd1)) != 3'd0;
    base   = chop ? {addr[31:5], 5'd0} : {addr[31:6], 6'd0};
    nbeats = chop ? 4 : 8;
    exp    = mis ? 64'd0 : want(addr, sz);
    cnt0   = burst_count;
    @(negedge clk);
    req_valid = 1'b1; req_addr = addr; req_size = sz; chop_en = chop;
    chk(req_ready, "R7 idle ready", 64'(req_ready), 64'd1);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chop_en = ~chop; // R9: later change must not matter
    chk(!req_ready, "R7 ready low after accept", 64'(req_ready), 64'd0);
    if (mis) begin
      chk(rsp_valid && rsp_err, "R6 error response", {62'd0, rsp_valid, rsp_err}, 64'd3);
      chk(rsp_data == 64'd0, "R6 error data zero", rsp_data, 64'd0);
      chk(!mem_cmd_valid, "R6 no command", 64'(mem_cmd_valid), 64'd0);
    end else begin
      chk(mem_cmd_valid, "R1 command raised", 64'(mem_cmd_valid), 64'd1);
      chk(mem_cmd_addr == base, chop ? "R4 half-line address" : "R1 line address",
          64'(mem_cmd_addr), 64'(base));
      chk(mem_cmd_chop == chop, "R9 chop sampled at accept", 64'(mem_cmd_chop), 64'(chop));
      for (int g = 0; g < gap_cmd; g++) begin
        @(negedge clk);
        chk(mem_cmd_valid && burst_count == cnt0, "R5 no count while stalled",
            64'(burst_count), 64'(cnt0));
      end
      mem_cmd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_cmd_ready = 1'b0;
      chk(burst_count == cnt0 + 16'd1, "R5 count step", 64'(burst_count), 64'(cnt0 + 16'd1));
      for (int b = 0; b < nbeats; b++) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = mbeat(base + 32'(8 * b));
        @(posedge clk);
        @(negedge clk);
        mem_rd_valid = 1'b0;
        mem_rd_data  = 64'hDEAD_BEEF_0BAD_F00D;
        if (b == 1) @(negedge clk);  // idle gap between beats
        if (b < nbeats - 1)
          chk(!rsp_valid, chop ? "R4 not done early" : "R2 full burst consumed",
              64'(rsp_valid), 64'd0);
      end
      chk(rsp_valid && !rsp_err, chop ? "R4 response after 4 beats" : "R2 response after 8 beats",
          64'(rsp_valid), 64'd1);
      chk(rsp_data == exp, "R3 extracted bytes", rsp_data, exp);
    end
    chk(burst_count == (mis ? cnt0 : cnt0 + 16'd1), "R5 count per read",
        64'(burst_count), 64'(mis ? cnt0 : cnt0 + 16'd1));
    for (int h = 0; h < hold_rsp; h++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_data == exp && rsp_err == mis, "R8 response held", rsp_data, exp);
      chk(!req_ready, "R7 ready low while pending", 64'(req_ready), 64'd0);
    end
    rsp_ready = 1'b1;
    @(posedge clk);
    @(negedge clk);
    rsp_ready = 1'b0;
    chk(!rsp_valid && req_ready, "R7 ready back after response", 64'(req_ready), 64'd1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(req_ready, "R10 req_ready", 64'(req_ready), 64'd1);
    chk(!rsp_valid, "R10 rsp_valid", 64'(rsp_valid), 64'd0);
    chk(!mem_cmd_valid, "R10 mem_cmd_valid", 64'(mem_cmd_valid), 64'd0);
    chk(burst_count == 16'd0, "R10 burst_count", 64'(burst_count), 64'd0);
    rst_n = 1'b1;
  endtask

  task automatic t_full_sizes();
    do_read(32'h0000_102B, 2'd0, 1'b0, 0, 0);
    do_read(32'h0000_2036, 2'd1, 1'b0, 0, 0);
    do_read(32'h0000_30F4, 2'd2, 1'b0, 0, 0);
    do_read(32'h0000_4038, 2'd3, 1'b0, 0, 0);
    do_read(32'h0000_4000, 2'd3, 1'b0, 0, 0);
  endtask

  task automatic t_chop();
    do_read(32'h0000_5074, 2'd2, 1'b1, 0, 0);
    do_read(32'h0000_6008, 2'd3, 1'b1, 0, 0);
    do_read(32'h0000_611F, 2'd0, 1'b1, 0, 0);
  endtask

  task automatic t_misaligned();
    do_read(32'h0000_7001, 2'd1, 1'b0, 0, 0);
    do_read(32'h0000_7004, 2'd3, 1'b1, 0, 2);
    do_read(32'h0000_7006, 2'd2, 1'b0, 0, 0);
  endtask

  task automatic t_backpressure();
    do_read(32'h0000_8012, 2'd1, 1'b0, 3, 4);
    do_read(32'h0000_8030, 2'd2, 1'b1, 2, 3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    t_reset();
    t_full_sizes();
    t_chop();
    t_misaligned();
    t_backpressure();
    repeat (2) @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule